// File: doc/BRIEF.md
# Packed Vertex Attribute Loader

This block takes a stream of 32-bit register writes that carry default vertex attribute data. Every three accepted words hold four 24-bit floating-point components. The block unpacks them into one four-component vector. It treats the component values as opaque bit fields and does no arithmetic on them.

A setup index decides where each finished vector goes:

- An index below the last table entry writes the vector into a table of default attributes, then advances the index.
- An index equal to the last entry sends the vector to an immediate-mode vertex buffer. That buffer fills attribute slots up to a programmed maximum. It then raises a one-cycle strobe while presenting the whole assembled vertex.
- An index past the end of the table drops the vector and reports an error.

A configuration port loads the setup index and the maximum slot number. A combinational read port exposes any table entry.

Top module: `vattr_loader`

## Requirements
- R1: A word is accepted only in a cycle with `wr_en` high. Idle cycles between words are ignored. A word counter wraps to zero after the third accepted word, and a vector is produced only on that third word.
- R2: For accepted words a, b, c, the vector has W = a[31:8], Z = {a[7:0], b[31:16]}, Y = {b[15:0], c[31:24]} and X = c[23:0]. On `rd_vec` and in each vertex slot, X is at [95:72], Y at [71:48], Z at [47:24] and W at [23:0].
- R3: A synchronous reset `rst` clears the word counter, the setup index, the maximum slot, the immediate slot, the table and the immediate buffer. It also drives `err_o` and `vtx_valid` low.
- R4: A vector completing with the setup index at 16 or above is discarded. The table is unchanged, the index is unchanged, and `err_o` is high for exactly the one cycle after the completing edge.
- R5: A vector completing with the setup index below 15 is written to the table at that index, and the index then increments by one.
- R6: A vector completing with the setup index at 15 goes to the immediate buffer at the current slot, not to the table. The index stays 15. The slot increments while it is below the maximum slot.
- R7: When a vector is placed in the slot equal to the maximum, the slot returns to zero and `vtx_valid` is high for one cycle after that edge. During that cycle `vtx_data` carries slot k at bits [k*96 +: 96].
- R8: A `cfg_we` cycle loads the setup index and maximum slot, and they take effect from the next cycle. A vector completing in that same cycle still uses the old index and maximum.
- R9: `rd_vec` combinationally shows the table entry selected by `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Attribute data word valid |
| wr_data | input | 32 | Attribute data word |
| cfg_we | input | 1 | Load setup index and maximum slot |
| cfg_index | input | 5 | New setup index |
| cfg_max | input | 4 | New maximum immediate slot |
| rd_addr | input | 4 | Table read address |
| rd_vec | output | 96 | Table entry {X,Y,Z,W} |
| err_o | output | 1 | Discarded-vector pulse |
| vtx_valid | output | 1 | Immediate vertex complete pulse |
| vtx_data | output | 1536 | All immediate slots, slot k at [k*96 +: 96] |

## Verification
Two functions can land in the same cycle: a configuration write, and the third word of a vector that then routes using the index. The bench provokes the overlap by raising `cfg_we` with a new index on the very cycle of a vector's last word. It then expects the vector at the old index in the table and the following vector at the newly loaded index. A further check confirms that the entry just after the old index stays empty.

// File: rtl/vattr_pkg.sv
package vattr_pkg;
  localparam int WORD_W = 32;
  localparam int COMP_W = 24;
  localparam int VEC_W  = 4 * COMP_W;

  typedef struct packed {
    logic [COMP_W-1:0] x;
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] z;
    logic [COMP_W-1:0] w;
  } vec4_t;

  // Three packed words carry W, Z, Y, X from the top of the first word down.
  function automatic vec4_t unpack_words(input logic [WORD_W-1:0] a,
                                         input logic [WORD_W-1:0] b,
                                         input logic [WORD_W-1:0] c);
    vec4_t v;
    v.w = a[31:8];
    v.z = {a[7:0], b[31:16]};
    v.y = {b[15:0], c[31:24]};
    v.x = c[23:0];
    return v;
  endfunction
endpackage

// File: rtl/vattr_accum.sv
module vattr_accum
  import vattr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              vec_done,
  output vec4_t             vec,
  output logic [1:0]        cnt
);
  logic [1:0]        cnt_q;
  logic [WORD_W-1:0] w0_q, w1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= 2'd0;
      w0_q  <= '0;
      w1_q  <= '0;
    end else if (wr_en) begin
      case (cnt_q)
        2'd0:    begin w0_q <= wr_data; cnt_q <= 2'd1; end
        2'd1:    begin w1_q <= wr_data; cnt_q <= 2'd2; end
        default: cnt_q <= 2'd0;
      endcase
    end
  end

  // The third word completes the vector in the cycle it arrives.
  assign vec_done = wr_en && (cnt_q == 2'd2);
  assign vec      = unpack_words(w0_q, w1_q, wr_data);
  assign cnt      = cnt_q;
endmodule

// File: rtl/vattr_table.sv
module vattr_table
  import vattr_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [VEC_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [VEC_W-1:0] rdata
);
  logic [VEC_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/vattr_imm.sv
module vattr_imm
  import vattr_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [VEC_W-1:0]       vec,
  input  logic [SW-1:0]          max_slot,
  output logic [SW-1:0]          slot,
  output logic                   vtx_valid,
  output logic [SLOTS*VEC_W-1:0] vtx_data
);
  logic [VEC_W-1:0] buf_q [SLOTS];
  logic [SW-1:0]    slot_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      valid_q <= 1'b0;
      for (int i = 0; i < SLOTS; i++) buf_q[i] <= '0;
    end else begin
      valid_q <= 1'b0;
      if (push) begin
        buf_q[slot_q] <= vec;
        if (slot_q < max_slot) begin
          slot_q <= slot_q + 1'b1;
        end else begin
          slot_q  <= '0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_flat
    assign vtx_data[k*VEC_W +: VEC_W] = buf_q[k];
  end

  assign slot      = slot_q;
  assign vtx_valid = valid_q;
endmodule

// File: rtl/vattr_loader.sv
module vattr_loader
  import vattr_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SLOTS   = 16,
  parameter int IDX_W   = 5,
  localparam int TAW    = $clog2(ENTRIES),
  localparam int SAW    = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_index,
  input  logic [SAW-1:0]         cfg_max,
  input  logic [TAW-1:0]         rd_addr,
  output logic [VEC_W-1:0]       rd_vec,
  output logic                   err_o,
  output logic                   vtx_valid,
  output logic [SLOTS*VEC_W-1:0] vtx_data
);
  localparam logic [IDX_W-1:0] IMM_IDX = IDX_W'(ENTRIES - 1);

  // Named internal events, observed by the bound checker.
  logic             vec_done;
  vec4_t            vec;
  logic [1:0]       cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [SAW-1:0]   max_q;
  logic [SAW-1:0]   slot_q;
  logic             tbl_we, imm_push, bad_idx, err_q;

  vattr_accum u_accum (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .vec_done(vec_done), .vec(vec), .cnt(cnt_q)
  );

  assign bad_idx  = idx_q > IMM_IDX;
  assign tbl_we   = vec_done && (idx_q < IMM_IDX);
  assign imm_push = vec_done && (idx_q == IMM_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      max_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= vec_done && bad_idx;
      if (cfg_we) begin
        idx_q <= cfg_index;
        max_q <= cfg_max;
      end else if (tbl_we) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  vattr_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(idx_q[TAW-1:0]),
    .wdata(vec), .raddr(rd_addr), .rdata(rd_vec)
  );

  vattr_imm #(.SLOTS(SLOTS)) u_imm (
    .clk(clk), .rst(rst), .push(imm_push), .vec(vec), .max_slot(max_q),
    .slot(slot_q), .vtx_valid(vtx_valid), .vtx_data(vtx_data)
  );

  assign err_o = err_q;
endmodule

// File: rtl/vattr_loader_chk.sv
module vattr_loader_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 5,
  parameter int SAW     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_index,
  input logic             vec_done,
  input logic [1:0]       cnt_q,
  input logic [IDX_W-1:0] idx_q,
  input logic [SAW-1:0]   slot_q,
  input logic             err_o,
  input logic             vtx_valid
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q != 2'd3);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (rst)
    (vec_done && idx_q < LAST && !cfg_we) |=> idx_q == $past(idx_q) + 1'b1);

  p_idx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (vec_done && idx_q > LAST && !cfg_we) |=> ($stable(idx_q) && err_o));

  p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  p_imm_idx_r6: assert property (@(posedge clk) disable iff (rst)
    (vec_done && idx_q == LAST && !cfg_we) |=> idx_q == LAST);

  p_vtx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    vtx_valid |=> !vtx_valid);

  p_slot_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    vtx_valid |-> slot_q == '0);

  p_cfg_load_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> idx_q == $past(cfg_index));
endmodule

bind vattr_loader vattr_loader_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .SAW(SAW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_index(cfg_index),
  .vec_done(vec_done), .cnt_q(cnt_q), .idx_q(idx_q), .slot_q(slot_q),
  .err_o(err_o), .vtx_valid(vtx_valid)
);

// File: tb/vattr_loader_test.sv
module vattr_loader_test;
  localparam int VW = 96;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_index = '0;
  logic [3:0]    cfg_max = '0;
  logic [3:0]    rd_addr = '0;
  logic [VW-1:0] rd_vec;
  logic          err_o, vtx_valid;
  logic [16*VW-1:0] vtx_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vattr_loader uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_index(cfg_index), .cfg_max(cfg_max),
    .rd_addr(rd_addr), .rd_vec(rd_vec), .err_o(err_o),
    .vtx_valid(vtx_valid), .vtx_data(vtx_data)
  );

  // Stimulus vectors: {word0, word1, word2}
  localparam logic [VW-1:0] STIM [6] = '{
    96'h123456_78_9ABC_DEF0_1122_3344,
    96'hFFEEDD_CC_BBAA_9988_7766_5544,
    96'h000001_80_0000_0100_00FF_0001,
    96'hA5A5A5_5A_C3C3_3C3C_F00F_0FF0,
    96'h800000_7F_FFFF_0000_1357_9BDF,
    96'h0F0F0F_F0_1234_8765_CAFE_BABE
  };

  // Concatenated words read as W,Z,Y,X from the top; result is {X,Y,Z,W}.
  function automatic logic [VW-1:0] expect_vec(input logic [VW-1:0] p);
    return {p[23:0], p[47:24], p[71:48], p[95:72]};
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_vec(input logic [VW-1:0] p);
    put(p[95:64]);
    @(negedge clk);
    put(p[63:32]);
    put(p[31:0]);
  endtask

  task automatic cfg(input logic [4:0] idx, input logic [3:0] mx);
    cfg_we = 1'b1; cfg_index = idx; cfg_max = mx;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [VW-1:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_vec, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: reset state
    rd_chk("R3 table after reset", 4'd0, '0);
    chk("R3 vtx_valid after reset", VW'(vtx_valid), '0);
    chk("R3 err after reset", VW'(err_o), '0);

    // R1, R2, R5, R9: table walk with gaps between words
    for (int i = 0; i < 6; i++) begin
      put(STIM[i][95:64]);
      @(negedge clk);
      put(STIM[i][63:32]);
      rd_chk("R1 no vector before third word", 4'(i), '0);
      put(STIM[i][31:0]);
      rd_chk("R2 R5 unpacked entry", 4'(i), expect_vec(STIM[i]));
    end

    // R8: config write in the same cycle as a third word (index is 6)
    put(STIM[1][95:64]);
    put(STIM[1][63:32]);
    cfg_we = 1'b1; cfg_index = 5'd9; cfg_max = 4'd0;
    put(STIM[1][31:0]);
    cfg_we = 1'b0;
    rd_chk("R8 completing vector uses old index", 4'd6, expect_vec(STIM[1]));
    put_vec(STIM[2]);
    rd_chk("R8 next vector at loaded index", 4'd9, expect_vec(STIM[2]));
    rd_chk("R8 old index plus one untouched", 4'd7, '0);

    // R4: out-of-range index
    cfg(5'd20, 4'd0);
    put_vec(STIM[3]);
    chk("R4 error pulse", VW'(err_o), VW'(1));
    @(negedge clk);
    chk("R4 error one cycle", VW'(err_o), '0);
    put_vec(STIM[4]);
    chk("R4 index held, error again", VW'(err_o), VW'(1));
    rd_chk("R4 table untouched", 4'd10, '0);

    // R6, R7: immediate vertex assembly, max slot 2
    cfg(5'd15, 4'd2);
    put_vec(STIM[0]);
    chk("R6 no strobe slot0", VW'(vtx_valid), '0);
    rd_chk("R6 table entry 15 untouched", 4'd15, '0);
    put_vec(STIM[1]);
    chk("R6 no strobe slot1", VW'(vtx_valid), '0);
    put_vec(STIM[2]);
    chk("R7 strobe at max", VW'(vtx_valid), VW'(1));
    chk("R7 slot0 data", vtx_data[0*VW +: VW], expect_vec(STIM[0]));
    chk("R7 slot1 data", vtx_data[1*VW +: VW], expect_vec(STIM[1]));
    chk("R7 slot2 data", vtx_data[2*VW +: VW], expect_vec(STIM[2]));
    @(negedge clk);
    chk("R7 strobe one cycle", VW'(vtx_valid), '0);
    put_vec(STIM[3]);
    chk("R7 slot restarted, no strobe", VW'(vtx_valid), '0);
    chk("R7 wrap writes slot0", vtx_data[0*VW +: VW], expect_vec(STIM[3]));
    put_vec(STIM[4]);
    put_vec(STIM[5]);
    chk("R7 second vertex strobe", VW'(vtx_valid), VW'(1));
    cfg(5'd15, 4'd0);
    put_vec(STIM[1]);
    chk("R7 max zero strobes every vector", VW'(vtx_valid), VW'(1));
    chk("R7 max zero slot0", vtx_data[0*VW +: VW], expect_vec(STIM[1]));
    rd_chk("R6 entry 15 still empty", 4'd15, '0);

    // R3: reset with a partial vector pending
    put(32'hDEAD_BEEF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk("R3 table cleared", 4'd0, '0);
    chk("R3 immediate buffer cleared", vtx_data[0*VW +: VW], '0);
    put_vec(STIM[5]);
    rd_chk("R3 counter and index cleared", 4'd0, expect_vec(STIM[5]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule